// File: doc/BRIEF.md
# Programmable CRT Raster Timing Generator

This block produces the raster timing for a cathode-ray-tube style display: a horizontal display window, horizontal blanking and horizontal retrace on a character-clock time base, and a vertical display window, vertical blanking and vertical retrace on a scan-line time base. A character counter advances on every clock and wraps at the end of each line. A line counter advances once per wrap and rolls over at the end of each frame. Each output is derived by comparing these counters with values held in a small programmable register set.

Software programs the block through a two-step write port. One write loads a 5-bit register index, and a second write stores a byte at that index. The register encodings are biased: the line total is stored as characters minus five, the frame total as lines minus two, and the display ends as the last active count. The 10-bit vertical values take their upper bits from a shared overflow byte. Span ends are partial matches on the low counter bits: 6 bits for horizontal blank, 5 for horizontal retrace, 4 for vertical retrace and 8 for vertical blank. A protect bit locks the horizontal and overflow registers. A vertical-retrace interrupt has its own enable and clear bits and is reported, together with the retrace and display flags, on a status byte. The write port has no back-pressure: every write is taken in the cycle it is presented.

Top module: `crtc_timing`

## Requirements
- R1: The character counter counts 0 up to (index 00h value + 4) and then returns to 0, so a line is index 00h + 5 clocks long.
- R2: `disp_en` is high while the character count is at most the index 01h value and the line count is at most the vertical display end, so each displayed line has index 01h + 1 active clocks.
- R3: `h_blank` goes high at the character equal to index 02h. It stays high until a character whose low 6 bits equal the 6-bit blank end. Bits 4:0 of that value come from index 03h bits 4:0 and bit 5 comes from index 05h bit 7. `h_blank` is low in the matching character, and an end match overrides a start match.
- R4: `h_retrace` goes high at the character equal to index 04h. It is low again from the first character whose low 5 bits equal index 05h bits 4:0, and an end match overrides a start match.
- R5: The line counter advances once per character-counter wrap. A frame is (vertical total + 2) lines, where the 10-bit vertical total takes bits 7:0 from index 06h, bit 8 from index 07h bit 0 and bit 9 from index 07h bit 5.
- R6: The vertical display end is 10 bits: bits 7:0 from index 12h, bit 8 from index 07h bit 1 and bit 9 from index 07h bit 6. Lines 0 up to this value are displayed.
- R7: `v_retrace` goes high on the line equal to the 10-bit retrace start. That value takes bits 7:0 from index 10h, bit 8 from index 07h bit 2 and bit 9 from index 07h bit 7. `v_retrace` ends on the first line whose low 4 bits equal index 11h bits 3:0.
- R8: `v_blank` goes high on the line equal to the 10-bit blank start. That value takes bits 7:0 from index 15h, bit 8 from index 07h bit 3 and bit 9 from index 09h bit 5. `v_blank` ends on the first line whose low 8 bits equal index 16h.
- R9: While index 11h bit 7 is 1, data writes to indices 00h through 07h are ignored. Index 11h itself stays writable.
- R10: When index 11h bit 5 is 0 and bit 4 is 1, a rising edge of `v_retrace` sets `irq` one clock later. While bit 4 is 0, `irq` is cleared and held low. While bit 5 is 1, `irq` is never set.
- R11: `status` carries `irq` on bit 7, `v_retrace` on bit 3 and the inverse of `disp_en` on bit 0. All other status bits are 0.
- R12: A synchronous active-low reset clears every register, both counters, every span flag and the interrupt.
- R13: `wr_idx_en` loads the index from `wr_data[4:0]`. `wr_dat_en` stores `wr_data` at the current index. Writes to indices above 18h change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_idx_en | input | 1 | Load register index from wr_data[4:0] |
| wr_dat_en | input | 1 | Write wr_data to the indexed register |
| wr_data | input | 8 | Index or register data |
| disp_en | output | 1 | Combined horizontal and vertical display window |
| h_blank | output | 1 | Horizontal blanking |
| h_retrace | output | 1 | Horizontal retrace (sync) |
| v_blank | output | 1 | Vertical blanking |
| v_retrace | output | 1 | Vertical retrace (sync) |
| irq | output | 1 | Vertical retrace interrupt pending |
| status | output | 8 | Status byte: irq, v_retrace, display inactive |

## Verification
The assertions check on every cycle that the character counter wraps exactly at the programmed limit and that the line counter holds between wraps. They also check that a retrace span only ends on its partial match and only starts on the full retrace start line, that protected writes leave the locked fields unchanged, and that the interrupt only rises after a vertical retrace and falls while the clear bit is low. The bench scenarios show the measured lengths: line length, display width, blank and retrace widths, and the effect of the overflow bits on frame length. They also cover wrap-around partial matches across a line end and the full interrupt sequence of set, clear and disable as seen on `irq` and `status`.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int REG_W   = 8;
  localparam int IDX_W   = 5;
  localparam int NUM_IDX = 25;
  localparam int HC_W    = REG_W + 1;
  localparam int VV_W    = 10;
  localparam int VC_W    = VV_W + 1;
  localparam int HBE_W   = 6;
  localparam int HRE_W   = 5;
  localparam int VRE_W   = 4;
  localparam int VBE_W   = 8;
  localparam int PROT_LAST = 7;

  // register slots whose position is decoded by the timing logic
  localparam int IX_HTOT = 0;
  localparam int IX_HDE  = 1;
  localparam int IX_HBS  = 2;
  localparam int IX_HBE  = 3;
  localparam int IX_HRS  = 4;
  localparam int IX_HRE  = 5;
  localparam int IX_VTOT = 6;
  localparam int IX_OVF  = 7;
  localparam int IX_MSL  = 9;
  localparam int IX_VRS  = 16;
  localparam int IX_VCTL = 17;
  localparam int IX_VDE  = 18;
  localparam int IX_VBS  = 21;
  localparam int IX_VBE  = 22;

  typedef struct packed {
    logic [REG_W-1:0] htot;
    logic [REG_W-1:0] hde;
    logic [REG_W-1:0] hbs;
    logic [HBE_W-1:0] hbe;
    logic [REG_W-1:0] hrs;
    logic [HRE_W-1:0] hre;
    logic [VV_W-1:0]  vtot;
    logic [VV_W-1:0]  vde;
    logic [VV_W-1:0]  vrs;
    logic [VV_W-1:0]  vbs;
    logic [VRE_W-1:0] vre;
    logic [VBE_W-1:0] vbe;
    logic             wprot;
    logic             vint_off;
    logic             vint_run;
  } crtc_cfg_t;

  function automatic bit slot_used(input int i);
    case (i)
      IX_HTOT, IX_HDE, IX_HBS, IX_HBE, IX_HRS, IX_HRE, IX_VTOT, IX_OVF,
      IX_MSL, IX_VRS, IX_VCTL, IX_VDE, IX_VBS, IX_VBE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_idx_en,
  input  logic             wr_dat_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [IDX_W-1:0] cur_idx,
  output crtc_cfg_t        cfg
);
  logic [NUM_IDX-1:0][REG_W-1:0] slot;
  logic                          locked;

  always_ff @(posedge clk) begin
    if (!rst_n)         cur_idx <= '0;
    else if (wr_idx_en) cur_idx <= wr_data[IDX_W-1:0];
  end

  assign locked = slot[IX_VCTL][7];

  for (genvar i = 0; i < NUM_IDX; i++) begin : g_slot
    if (slot_used(i)) begin : g_live
      logic [REG_W-1:0] q;
      logic             hit;
      assign hit = wr_dat_en && (cur_idx == IDX_W'(i)) &&
                   !(locked && (i <= PROT_LAST));
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wr_data;
      end
      assign slot[i] = q;
    end else begin : g_none
      assign slot[i] = '0;
    end
  end

  always_comb begin
    cfg          = '0;
    cfg.htot     = slot[IX_HTOT];
    cfg.hde      = slot[IX_HDE];
    cfg.hbs      = slot[IX_HBS];
    cfg.hbe      = {slot[IX_HRE][7], slot[IX_HBE][4:0]};
    cfg.hrs      = slot[IX_HRS];
    cfg.hre      = slot[IX_HRE][4:0];
    cfg.vtot     = {slot[IX_OVF][5], slot[IX_OVF][0], slot[IX_VTOT]};
    cfg.vde      = {slot[IX_OVF][6], slot[IX_OVF][1], slot[IX_VDE]};
    cfg.vrs      = {slot[IX_OVF][7], slot[IX_OVF][2], slot[IX_VRS]};
    cfg.vbs      = {slot[IX_MSL][5], slot[IX_OVF][3], slot[IX_VBS]};
    cfg.vre      = slot[IX_VCTL][3:0];
    cfg.vbe      = slot[IX_VBE];
    cfg.wprot    = slot[IX_VCTL][7];
    cfg.vint_off = slot[IX_VCTL][5];
    cfg.vint_run = slot[IX_VCTL][4];
  end
endmodule

// File: rtl/crtc_hseq.sv
module crtc_hseq
  import crtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] htot,
  output logic [HC_W-1:0]  hcnt,
  output logic             h_last
);
  localparam logic [HC_W-1:0] BIAS = HC_W'(4);
  logic [HC_W-1:0] lim;

  assign lim    = {1'b0, htot} + BIAS;
  assign h_last = (hcnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)      hcnt <= '0;
    else if (h_last) hcnt <= '0;
    else             hcnt <= hcnt + HC_W'(1);
  end
endmodule

// File: rtl/crtc_vseq.sv
module crtc_vseq
  import crtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [VV_W-1:0] vtot,
  output logic [VC_W-1:0] vcnt
);
  logic [VC_W-1:0] lim;
  assign lim = {1'b0, vtot} + VC_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) vcnt <= '0;
    else if (step) begin
      if (vcnt == lim) vcnt <= '0;
      else             vcnt <= vcnt + VC_W'(1);
    end
  end
endmodule

// File: rtl/crtc_span.sv
module crtc_span #(
  parameter int CW = 9,
  parameter int SW = 8,
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [SW-1:0] start,
  input  logic [EW-1:0] stop,
  output logic          active
);
  logic q;
  logic hit_s;
  logic hit_e;

  assign hit_s  = (cnt == CW'(start));
  assign hit_e  = (cnt[EW-1:0] == stop);
  assign active = !hit_e && (hit_s || q);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= active;
  end
endmodule

// File: rtl/crtc_vint.sv
module crtc_vint (
  input  logic clk,
  input  logic rst_n,
  input  logic v_retrace,
  input  logic vint_off,
  input  logic vint_run,
  output logic pending
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      pending <= 1'b0;
    end else begin
      prev <= v_retrace;
      if (!vint_run)
        pending <= 1'b0;
      else if (v_retrace && !prev && !vint_off)
        pending <= 1'b1;
    end
  end
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
  import crtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_idx_en,
  input  logic             wr_dat_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             disp_en,
  output logic             h_blank,
  output logic             h_retrace,
  output logic             v_blank,
  output logic             v_retrace,
  output logic             irq,
  output logic [REG_W-1:0] status
);
  crtc_cfg_t        cfg;
  logic [IDX_W-1:0] cur_idx;
  logic [HC_W-1:0]  hcnt;
  logic [VC_W-1:0]  vcnt;
  logic             h_last;
  logic             h_de;
  logic             v_de;

  crtc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_idx_en(wr_idx_en), .wr_dat_en(wr_dat_en),
    .wr_data(wr_data), .cur_idx(cur_idx), .cfg(cfg)
  );

  crtc_hseq u_hseq (
    .clk(clk), .rst_n(rst_n), .htot(cfg.htot), .hcnt(hcnt), .h_last(h_last)
  );

  crtc_vseq u_vseq (
    .clk(clk), .rst_n(rst_n), .step(h_last), .vtot(cfg.vtot), .vcnt(vcnt)
  );

  crtc_span #(.CW(HC_W), .SW(REG_W), .EW(HBE_W)) u_hblank (
    .clk(clk), .rst_n(rst_n), .cnt(hcnt), .start(cfg.hbs), .stop(cfg.hbe),
    .active(h_blank)
  );

  crtc_span #(.CW(HC_W), .SW(REG_W), .EW(HRE_W)) u_hret (
    .clk(clk), .rst_n(rst_n), .cnt(hcnt), .start(cfg.hrs), .stop(cfg.hre),
    .active(h_retrace)
  );

  crtc_span #(.CW(VC_W), .SW(VV_W), .EW(VRE_W)) u_vret (
    .clk(clk), .rst_n(rst_n), .cnt(vcnt), .start(cfg.vrs), .stop(cfg.vre),
    .active(v_retrace)
  );

  crtc_span #(.CW(VC_W), .SW(VV_W), .EW(VBE_W)) u_vblank (
    .clk(clk), .rst_n(rst_n), .cnt(vcnt), .start(cfg.vbs), .stop(cfg.vbe),
    .active(v_blank)
  );

  crtc_vint u_vint (
    .clk(clk), .rst_n(rst_n), .v_retrace(v_retrace), .vint_off(cfg.vint_off),
    .vint_run(cfg.vint_run), .pending(irq)
  );

  assign h_de    = (hcnt <= {1'b0, cfg.hde});
  assign v_de    = (vcnt <= {1'b0, cfg.vde});
  assign disp_en = h_de && v_de;
  assign status  = {irq, 3'b000, v_retrace, 2'b00, !disp_en};
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
  import crtc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_dat_en,
  input logic [IDX_W-1:0] cur_idx,
  input crtc_cfg_t        cfg,
  input logic [HC_W-1:0]  hcnt,
  input logic [VC_W-1:0]  vcnt,
  input logic             h_retrace,
  input logic             v_retrace,
  input logic             irq
);
  assert_hwrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == ({1'b0, cfg.htot} + HC_W'(4))) |=> (hcnt == '0));

  assert_vhold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != ({1'b0, cfg.htot} + HC_W'(4))) |=> $stable(vcnt));

  assert_hret_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h_retrace) |-> (hcnt[HRE_W-1:0] == cfg.hre));

  assert_vret_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v_retrace) |-> (vcnt == {1'b0, cfg.vrs}));

  assert_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat_en && cfg.wprot && (cur_idx <= IDX_W'(PROT_LAST)))
    |=> ($stable(cfg.htot) && $stable(cfg.hde) && $stable(cfg.hrs) && $stable(cfg.vtot)));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(v_retrace));

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.vint_run |=> !irq);
endmodule

bind crtc_timing crtc_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_dat_en(wr_dat_en), .cur_idx(cur_idx),
  .cfg(cfg), .hcnt(hcnt), .vcnt(vcnt), .h_retrace(h_retrace),
  .v_retrace(v_retrace), .irq(irq)
);

// File: tb/sim_crtc_timing.sv
`timescale 1ns/1ps
module sim_crtc_timing;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_idx_en;
  logic       wr_dat_en;
  logic [7:0] wr_data;
  logic       disp_en, h_blank, h_retrace, v_blank, v_retrace, irq;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  crtc_timing u0 (
    .clk(clk), .rst_n(rst_n), .wr_idx_en(wr_idx_en), .wr_dat_en(wr_dat_en),
    .wr_data(wr_data), .disp_en(disp_en), .h_blank(h_blank),
    .h_retrace(h_retrace), .v_blank(v_blank), .v_retrace(v_retrace),
    .irq(irq), .status(status)
  );

  // htot hde hbs hbe hrs hre | line de blank ret
  localparam int NV = 5;
  localparam int TBL [NV][10] = '{
    '{20, 15, 17, 23, 18, 21,  25, 16,  6,  3},
    '{75, 63, 64, 14, 40,  3,  80, 64, 14, 27},
    '{95, 79, 82, 34, 84, 26, 100, 80, 16,  6},
    '{ 0,  1,  2,  4,  3,  4,   5,  2,  2,  1},
    '{20, 15, 20,  2, 22,  1,  25, 16,  7,  4}
  };

  localparam int S_DE = 0, S_HB = 1, S_HR = 2, S_VB = 3, S_VR = 4;

  function automatic logic sig(input int sel);
    case (sel)
      S_DE:    return disp_en;
      S_HB:    return h_blank;
      S_HR:    return h_retrace;
      S_VB:    return v_blank;
      default: return v_retrace;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    wr_idx_en = 1'b1; wr_data = 8'(idx);
    @(negedge clk);
    wr_idx_en = 1'b0; wr_dat_en = 1'b1; wr_data = 8'(val);
    @(negedge clk);
    wr_dat_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic measure(input int sel, output int hi, output int per);
    logic prev, cur;
    bit   ended;
    int   n;
    hi = 0; per = 0; ended = 0; n = 0;
    @(negedge clk); prev = sig(sel);
    while (n < 20000) begin
      @(negedge clk); cur = sig(sel);
      if (!prev && cur) break;
      prev = cur; n++;
    end
    hi = 1; per = 1;
    while (per < 20000) begin
      @(negedge clk); cur = sig(sel);
      if (!ended) begin
        if (cur) hi++;
        else     ended = 1;
      end else if (cur) begin
        break;
      end
      per++;
    end
  endtask

  task automatic wait_level(input int sel, input logic lvl);
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (sig(sel) == lvl) break;
    end
  endtask

  task automatic wait_rise(input int sel);
    wait_level(sel, 1'b0);
    wait_level(sel, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, per, cnt;
    rst_n = 1'b0; wr_idx_en = 1'b0; wr_dat_en = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    // R12 reset state: all registers zero
    chk("R12 status in reset", int'(status), 0);
    chk("R12 irq in reset", int'(irq), 0);
    chk("R12 disp_en in reset", int'(disp_en), 1);
    chk("R12 h_blank in reset", int'(h_blank), 0);
    chk("R12 h_retrace in reset", int'(h_retrace), 0);
    chk("R12 v_retrace in reset", int'(v_retrace), 0);
    rst_n = 1'b1;

    // vertical frame for horizontal table: 12 lines, always displayed
    wr(6, 10); wr(7, 8'h42); wr(8'h12, 8'hFF);
    wr(8'h10, 200); wr(8'h15, 200); wr(8'h16, 0); wr(8'h11, 8'h10);

    for (int r = 0; r < NV; r++) begin
      wr(0, TBL[r][0]); wr(1, TBL[r][1]); wr(2, TBL[r][2]);
      wr(3, TBL[r][3] & 31); wr(4, TBL[r][4]);
      wr(5, (((TBL[r][3] >> 5) & 1) << 7) | TBL[r][5]);
      repeat (600) @(negedge clk);
      measure(S_DE, hi, per);
      chk($sformatf("R1 R13 line length row %0d", r), per, TBL[r][6]);
      chk($sformatf("R2 display width row %0d", r), hi, TBL[r][7]);
      measure(S_HB, hi, per);
      chk($sformatf("R3 blank width row %0d", r), hi, TBL[r][8]);
      measure(S_HR, hi, per);
      chk($sformatf("R4 retrace width row %0d", r), hi, TBL[r][9]);
    end

    // short frame: 10-char lines, 12 lines, display lines 0..7
    wr(0, 5); wr(1, 3); wr(6, 10); wr(7, 0); wr(8'h12, 7);
    wr(8'h10, 6); wr(8'h11, 8'h18); wr(8'h15, 3); wr(8'h16, 5);
    repeat (300) @(negedge clk);
    measure(S_VR, hi, per);
    chk("R7 v_retrace lines 6..7", hi, 20);
    chk("R5 frame period", per, 120);
    measure(S_VB, hi, per);
    chk("R8 v_blank lines 3..4", hi, 20);
    cnt = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (disp_en) cnt++;
    end
    chk("R6 displayed clocks per frame", cnt, 32);

    // write protection
    wr(8'h11, 8'h98); wr(0, 20);
    repeat (50) @(negedge clk);
    measure(S_DE, hi, per);
    chk("R9 protected htot write ignored", per, 10);
    wr(8'h11, 8'h18); wr(0, 20);
    repeat (50) @(negedge clk);
    measure(S_DE, hi, per);
    chk("R9 unprotected htot write applied", per, 25);
    wr(0, 5);
    repeat (50) @(negedge clk);

    // interrupt
    wr(8'h11, 8'h08);
    @(negedge clk);
    chk("R10 clear bit low clears irq", int'(irq), 0);
    wait_level(S_VR, 1'b1);
    wr(8'h11, 8'h18);
    wait_rise(S_VR);
    chk("R10 irq not yet at retrace start", int'(irq), 0);
    chk("R11 status during retrace", int'(status), 8'h08);
    @(negedge clk);
    chk("R10 irq set after retrace start", int'(irq), 1);
    chk("R11 status with irq", int'(status), 8'h88);
    wr(8'h11, 8'h28); wr(8'h11, 8'h38);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (irq) cnt++;
    end
    chk("R10 disabled interrupt stays low", cnt, 0);

    // overflow bit 8: vtot 300, vrs 260, vre 7
    wr(6, 44); wr(8'h10, 4); wr(7, 8'h05); wr(8'h11, 8'h17);
    repeat (100) @(negedge clk);
    measure(S_VR, hi, per);
    chk("R7 retrace with start bit 8", hi, 30);
    chk("R5 frame with total bit 8", per, 3020);

    // overflow bit 9: vtot 600, vrs 520, vre 12, vbs 515, vbe 18
    wr(6, 88); wr(8'h10, 8); wr(7, 8'hA0); wr(8'h11, 8'h1C);
    wr(8'h15, 3); wr(9, 8'h20); wr(8'h16, 18);
    repeat (100) @(negedge clk);
    measure(S_VR, hi, per);
    chk("R7 retrace with start bit 9", hi, 40);
    chk("R5 frame with total bit 9", per, 6020);
    measure(S_VB, hi, per);
    chk("R8 v_blank with start bit 9", hi, 150);

    // reset mid-run returns every register to zero
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    measure(S_DE, hi, per);
    chk("R12 period after reset", per, 10);
    chk("R12 display width after reset", hi, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule